// File: doc/BRIEF.md
# Pulse-and-Verify Programming Sequencer

This block is the controller half of a one-time-programmable memory programmer. After a start request it walks through the memory word by word in ascending address order. For each word it fetches the target value from a data source over a request/ready handshake and sets up address and data. It then fires a timed active-low program strobe and reads the word back. If the word does not match, it fires the strobe again, up to a fixed limit. A target of all ones already matches an erased cell, so it is passed over with no strobe at all.

Once every address has been handled, the sequencer drops both programming mode flags and makes a second pass over the whole array at normal conditions. On this pass it fetches each target again from the source and compares it with the read-back value. The outcome is reported as `done`, a `pass` flag, the failing address and the number of pulses applied to the most recently programmed word. The two supply conditions are modelled only as output flags. The elevated-supply flag always encloses the high-voltage flag in time.

Top module: `psq_prog_seq`

## Requirements
- R1: While reset is held and after its release until `start`, `done`=0, `pass`=0, `pgm_n`=1, `hv_en`=0, `sup_en`=0 and `src_req`=0.
- R2: Each program pulse holds `pgm_n` low for exactly CLK_MHZ*PULSE_US clock cycles.
- R3: `mem_addr` and `mem_wdata` are unchanged for at least SETUP_CYC cycles before `pgm_n` falls, stay unchanged while it is low, and stay unchanged for HOLD_CYC cycles after it rises.
- R4: After each pulse, all DATA_W bits of `mem_rdata` are compared with the target RD_CYC cycles later. A mismatch starts another pulse. A match moves on to the next address.
- R5: A word that still mismatches after MAX_PULSES (25) pulses stops the run. `done`=1, `pass`=0, `fail_addr` holds that address and `pulse_cnt`=25.
- R6: A target word of all ones (16'hFFFF) receives no pulse, and `pulse_cnt` becomes 0 for it.
- R7: Addresses are handled from 0 up to 2^ADDR_W-1. Each accepted `src_req`/`src_rdy` handshake delivers the target for the current `mem_addr`.
- R8: After the last address, `hv_en` and then `sup_en` fall, and a second pass re-fetches and compares every address from 0 with no pulses. The first mismatch gives `done`=1, `pass`=0 and `fail_addr` set to that address.
- R9: If every word verifies, `done`=1 and `pass`=1. `pulse_cnt` keeps the count of the last programmed word, and the result holds until the next `start`.
- R10: `hv_en` is never 1 while `sup_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle or finished |
| src_req | output | 1 | Requests the target word for `mem_addr` |
| src_rdy | input | 1 | Source presents `src_data`; handshake completes |
| src_data | input | DATA_W | Target word from the source |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Data presented to the memory during programming |
| mem_rdata | input | DATA_W | Read-back data from the memory |
| pgm_n | output | 1 | Active-low program pulse |
| hv_en | output | 1 | High programming voltage flag |
| sup_en | output | 1 | Elevated supply flag |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without error |
| fail_addr | output | ADDR_W | Address of the failing word |
| pulse_cnt | output | PCNT_W | Pulses applied to the latest programmed word |

## Verification
The bench builds the block with ADDR_W=3, CLK_MHZ=1, PULSE_US=4, SETUP_CYC=2, HOLD_CYC=1 and RD_CYC=2, and keeps MAX_PULSES at 25. Eight words and four-cycle pulses make full runs short. This lets the bench cover the retry limit exactly at 25 and beyond it, a final-pass failure behind a good first pass, and a run made only of erased words. The memory model needs a set number of pulses per word before it takes the data, and it can corrupt chosen words only when the programming flags are low.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAMP,
        S_FETCH,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_READ,
        S_NEXT,
        S_DROP,
        S_VFETCH,
        S_VREAD,
        S_PASS,
        S_FAIL
    } psq_state_e;

endpackage

// File: rtl/psq_timer.sv
module psq_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R2: an unloaded, non-zero count steps down by exactly one per cycle
    p_tmr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/psq_word_cmp.sv
module psq_word_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] target,
    input  logic [DATA_W-1:0] readback,
    output logic              match,
    output logic              erased
);
    assign match  = (target == readback);
    assign erased = &target;
endmodule

// File: rtl/psq_prog_seq.sv
module psq_prog_seq
    import psq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int CLK_MHZ    = 50,
    parameter int PULSE_US   = 100,
    parameter int SETUP_CYC  = 4,
    parameter int HOLD_CYC   = 4,
    parameter int RD_CYC     = 3,
    parameter int MAX_PULSES = 25,
    localparam int PCNT_W    = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              src_req,
    input  logic              src_rdy,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pgm_n,
    output logic              hv_en,
    output logic              sup_en,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [PCNT_W-1:0] pulse_cnt
);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
    localparam int T_A       = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int T_B       = (RD_CYC > T_A) ? RD_CYC : T_A;
    localparam int T_MAX     = (PULSE_CYC > T_B) ? PULSE_CYC : T_B;
    localparam int TMR_W     = $clog2(T_MAX + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        psq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [PCNT_W-1:0] pcnt;
        logic [ADDR_W-1:0] fail_addr;
        logic              pass;
        logic              sup;
        logic              hv;
    } psq_regs_t;

    psq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             word_match;
    logic             word_erased;
    logic             erased_unused;

    psq_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    psq_word_cmp #(.DATA_W(DATA_W)) u_verify (
        .target   (r_q.wdata),
        .readback (mem_rdata),
        .match    (word_match),
        .erased   (erased_unused)
    );

    psq_word_cmp #(.DATA_W(DATA_W)) u_blank (
        .target   (src_data),
        .readback (src_data),
        .match    (),
        .erased   (word_erased)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.state)
            S_IDLE, S_PASS, S_FAIL: begin
                if (start) begin
                    r_d.state     = S_RAMP;
                    r_d.sup       = 1'b1;
                    r_d.hv        = 1'b0;
                    r_d.addr      = '0;
                    r_d.pcnt      = '0;
                    r_d.pass      = 1'b0;
                    r_d.fail_addr = '0;
                end
            end
            S_RAMP: begin
                r_d.hv    = 1'b1;
                r_d.state = S_FETCH;
            end
            S_FETCH: begin
                if (src_rdy) begin
                    r_d.wdata = src_data;
                    r_d.pcnt  = '0;
                    if (word_erased) begin
                        r_d.state = S_NEXT;
                    end else begin
                        r_d.state = S_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(SETUP_CYC - 1);
                    end
                end
            end
            S_SETUP: begin
                if (tmr_zero) begin
                    r_d.state = S_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(PULSE_CYC - 1);
                end
            end
            S_PULSE: begin
                if (tmr_zero) begin
                    r_d.state = S_HOLD;
                    r_d.pcnt  = r_q.pcnt + 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(HOLD_CYC - 1);
                end
            end
            S_HOLD: begin
                if (tmr_zero) begin
                    r_d.state = S_READ;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(RD_CYC - 1);
                end
            end
            S_READ: begin
                if (tmr_zero) begin
                    if (word_match) begin
                        r_d.state = S_NEXT;
                    end else if (r_q.pcnt == PCNT_W'(MAX_PULSES)) begin
                        r_d.state     = S_FAIL;
                        r_d.fail_addr = r_q.addr;
                        r_d.hv        = 1'b0;
                        r_d.sup       = 1'b0;
                    end else begin
                        r_d.state = S_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(SETUP_CYC - 1);
                    end
                end
            end
            S_NEXT: begin
                if (r_q.addr == LAST_ADDR) begin
                    r_d.state = S_DROP;
                    r_d.hv    = 1'b0;
                end else begin
                    r_d.addr  = r_q.addr + 1'b1;
                    r_d.state = S_FETCH;
                end
            end
            S_DROP: begin
                r_d.sup   = 1'b0;
                r_d.addr  = '0;
                r_d.state = S_VFETCH;
            end
            S_VFETCH: begin
                if (src_rdy) begin
                    r_d.wdata = src_data;
                    r_d.state = S_VREAD;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(RD_CYC - 1);
                end
            end
            S_VREAD: begin
                if (tmr_zero) begin
                    if (!word_match) begin
                        r_d.state     = S_FAIL;
                        r_d.fail_addr = r_q.addr;
                    end else if (r_q.addr == LAST_ADDR) begin
                        r_d.state = S_PASS;
                        r_d.pass  = 1'b1;
                    end else begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.state = S_VFETCH;
                    end
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_req   = (r_q.state == S_FETCH) || (r_q.state == S_VFETCH);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign pgm_n     = (r_q.state != S_PULSE);
    assign hv_en     = r_q.hv;
    assign sup_en    = r_q.sup;
    assign done      = (r_q.state == S_PASS) || (r_q.state == S_FAIL);
    assign pass      = r_q.pass;
    assign fail_addr = r_q.fail_addr;
    assign pulse_cnt = r_q.pcnt;

    // R10: programming voltage only inside the elevated-supply window
    p_hv_in_sup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> sup_en);

    // R3: address and data frozen across the pulse and the hold after it
    p_pulse_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_n || r_q.state == S_HOLD) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    // R8: no pulse once the programming voltage is off
    p_no_pulse_cold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_en |-> pgm_n);

    // R5: the per-word pulse count never passes the limit
    p_pcnt_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PCNT_W'(MAX_PULSES));

    // R9: the result is held until a new start
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail_addr)));

    // R1: a finished or idle sequencer leaves the memory port quiet
    p_quiet_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pgm_n && !hv_en && !sup_en && !src_req));

endmodule

// File: tb/tb_psq_prog_seq.sv
`timescale 1ns/1ps
module tb_psq_prog_seq;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int NW = 1 << AW;
    localparam int PULSE_CYC = 4;
    localparam int SETUP_CYC = 2;
    localparam int MAXP = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic src_req, src_rdy = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata = '1;
    logic pgm_n, hv_en, sup_en, done, pass;
    logic [AW-1:0] fail_addr;
    logic [4:0] pulse_cnt;

    always #2.5 clk = ~clk;

    psq_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(1), .PULSE_US(4),
                   .SETUP_CYC(SETUP_CYC), .HOLD_CYC(1), .RD_CYC(2), .MAX_PULSES(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_req(src_req), .src_rdy(src_rdy), .src_data(src_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pgm_n(pgm_n), .hv_en(hv_en), .sup_en(sup_en),
        .done(done), .pass(pass), .fail_addr(fail_addr), .pulse_cnt(pulse_cnt));

    typedef struct {
        logic       pass;
        int         faddr;
        int         pcnt;
        int         pulses[NW];
    } exp_t;

    exp_t sb_q[$];
    int checks = 0, fails = 0;
    int cycles = 0;

    logic [DW-1:0] data_tab[NW], mem[NW], corrupt[NW];
    int need[NW], cnt[NW];
    int idx = 0;
    bit prev_hs = 0, stall = 0, prev_pgm = 1, prev_done = 0;
    int low_cnt = 0, stab = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_wdata = '0;
    int order_err = 0, sup_err = 0, cold_err = 0, width_err = 0, setup_err = 0;
    bit got_done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory, source and monitors all sampled on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (prev_hs) idx++;
            // R7: handshake must deliver the word for the current address
            if (src_req && src_rdy && (int'(mem_addr) != idx % NW)) order_err++;
            stall = ~stall;
            src_rdy = src_req & stall;
            src_data = data_tab[idx % NW];
            prev_hs = src_req && src_rdy;
            if (mem_addr != prev_addr || mem_wdata != prev_wdata) stab = 0;
            else stab++;
            prev_addr = mem_addr;
            prev_wdata = mem_wdata;
            if (prev_pgm && !pgm_n) begin
                if (stab < SETUP_CYC) setup_err++;        // R3
                cnt[mem_addr]++;
                if (cnt[mem_addr] == need[mem_addr]) mem[mem_addr] = mem[mem_addr] & mem_wdata;
            end
            if (!pgm_n) low_cnt++;
            else if (low_cnt != 0) begin
                if (low_cnt != PULSE_CYC) width_err++;     // R2
                low_cnt = 0;
            end
            if (hv_en && !sup_en) sup_err++;              // R10
            if (!pgm_n && !hv_en) cold_err++;             // R8
            prev_pgm = pgm_n;
            mem_rdata = mem[mem_addr] ^ (hv_en ? '0 : corrupt[mem_addr]);
            if (done && !prev_done) got_done = 1;
            prev_done = done;
        end
    end

    // scoreboard monitor: compares results when a run finishes
    initial begin
        forever begin
            @(negedge clk);
            if (got_done && sb_q.size() != 0) begin
                exp_t e;
                got_done = 0;
                e = sb_q.pop_front();
                chk(pass == e.pass, e.pass ? "R9 pass flag" : "R5/R8 pass flag", int'(pass), int'(e.pass));
                if (!e.pass) chk(int'(fail_addr) == e.faddr, "R5/R8 fail_addr", int'(fail_addr), e.faddr);
                chk(int'(pulse_cnt) == e.pcnt, "R5/R6/R9 pulse_cnt", int'(pulse_cnt), e.pcnt);
                for (int a = 0; a < NW; a++)
                    chk(cnt[a] == e.pulses[a], $sformatf("R4/R6 pulses word %0d", a), cnt[a], e.pulses[a]);
            end
        end
    end

    // driver: sets up the model, predicts the outcome, starts the run
    task automatic run_test(input int id);
        exp_t e;
        bit failed;
        logic [DW-1:0] base[NW] = '{16'h1234, 16'hFFFF, 16'h0000, 16'hA5A5,
                                    16'hFFFF, 16'h7FFE, 16'h0F0F, 16'h8001};
        int nb[NW] = '{1, 1, 3, 2, 1, 5, 1, 2};
        for (int a = 0; a < NW; a++) begin
            data_tab[a] = base[a]; need[a] = nb[a];
            corrupt[a] = '0; mem[a] = '1; cnt[a] = 0;
        end
        case (id)
            2: need[5] = 30;                                  // R5 beyond limit
            3: begin corrupt[2] = 16'h0010; corrupt[6] = 16'h0001; end  // R8
            4: need[2] = MAXP;                                // R5 exactly at limit
            5: for (int a = 0; a < NW; a++) data_tab[a] = '1; // R6 all erased
            default: ;
        endcase
        failed = 0; e.pass = 1; e.faddr = 0; e.pcnt = 0;
        for (int a = 0; a < NW; a++) begin
            e.pulses[a] = 0;
            if (!failed) begin
                if (&data_tab[a]) e.pcnt = 0;
                else if (need[a] > MAXP) begin
                    e.pulses[a] = MAXP; e.pcnt = MAXP; failed = 1; e.pass = 0; e.faddr = a;
                end else begin
                    e.pulses[a] = need[a]; e.pcnt = need[a];
                end
            end
        end
        if (!failed)
            for (int a = NW - 1; a >= 0; a--)
                if (corrupt[a] != '0) begin e.pass = 0; e.faddr = a; end
        sb_q.push_back(e);
        idx = 0; prev_hs = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!(done && sb_q.size() == 0) && cycles < 150000) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < NW; a++) begin
            data_tab[a] = '1; mem[a] = '1; corrupt[a] = '0; need[a] = 1; cnt[a] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk(!done && !pass && pgm_n && !hv_en && !sup_en && !src_req, "R1 in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!done && pgm_n && !hv_en && !sup_en && !src_req, "R1 idle after reset", int'(src_req), 0);
        for (int t = 1; t <= 5; t++) run_test(t);
        if (cycles >= 150000) chk(0, "watchdog", cycles, 150000);
        chk(order_err == 0, "R7 address order", order_err, 0);
        chk(width_err == 0, "R2 pulse width", width_err, 0);
        chk(setup_err == 0, "R3 setup time", setup_err, 0);
        chk(sup_err == 0, "R10 flag nesting", sup_err, 0);
        chk(cold_err == 0, "R8 no pulse in verify", cold_err, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        chk(0, "watchdog expired", cycles, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule